// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural register state of a 32-bit processor core that runs in several operating modes. A 4-bit register index is resolved against the current mode. Indices 0 to 7 always reach the same storage. The fast-interrupt mode swaps in its own copies of indices 8 to 14. The other four exception modes each swap in only their own stack pointer (index 13) and link register (index 14). Index 15 is the program counter. The block also keeps the current status word and one saved status word for each exception mode.

The block has two combinational read ports and one synchronous write port. A separate port advances the program counter, and the status word and the saved status word of the current mode can each be loaded directly. An exception-entry strobe switches to a target mode. On that edge it saves the old status word into the target's saved slot, writes the return address into the target's link register and clears the narrow-instruction flag. A return strobe copies the current mode's saved status word back into the current status word. Instruction decode, arithmetic, shifting and memory access belong to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, every general register and the program counter read as zero. The status word reads 0x000000D3, which is supervisor mode with the narrow flag clear. The saved word of supervisor mode reads zero.
- R2: Indices 0 to 7 reach the same storage in every mode. A value written in one mode reads back unchanged in any other mode.
- R3: In fast-interrupt mode (mode field, status bits [4:0], equal to 10001), indices 8 to 14 reach storage private to that mode.
- R4: In interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) mode, indices 13 and 14 reach storage private to each mode. Indices 8 to 12 reach the base storage.
- R5: User (10000) and system (11111) mode use only the base storage. Any mode-field value not listed in R3 to R5 behaves as user mode.
- R6: When exc_en is high and exc_mode names one of the five exception modes, the edge does four things. It stores the old status word into that mode's saved slot and writes exc_ret_addr into that mode's index 14. It sets status bits [4:0] to exc_mode and clears bit 5. With any other exc_mode value the strobe changes no state.
- R7: When exc_ret is high and exc_en is low in an exception mode, the edge copies that mode's saved word into the status word. In user or system mode the strobe leaves the status word unchanged. While either strobe is high, wr_en (including writes to index 15), st_wr_en and sv_wr_en are ignored.
- R8: In user or system mode, saved_o reads zero and sv_wr_en changes no saved word.
- R9: Reading index 15 returns pc_o + 8 when status bit 5 is 0, and pc_o + 4 when it is 1.
- R10: A write to index 15 takes priority over pc_wr_en. After every edge the stored program counter has bits [1:0] cleared if status bit 5 is 0, or bit 0 cleared if it is 1, using the status word in force after that edge.
- R11: A read of the index being written in the same cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index (15 loads the program counter) |
| wr_data | input | 32 | Register write data |
| pc_wr_en | input | 1 | Sequential program counter update |
| pc_wr_data | input | 32 | Next program counter value |
| st_wr_en | input | 1 | Load the status word |
| st_wr_data | input | 32 | New status word |
| sv_wr_en | input | 1 | Load the current mode's saved word |
| sv_wr_data | input | 32 | New saved word |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode of the entry |
| exc_ret_addr | input | 32 | Return address written to the target link register |
| exc_ret | input | 1 | Exception-return strobe |
| status_o | output | 32 | Current status word |
| saved_o | output | 32 | Saved word of the current mode (zero in user/system) |
| pc_o | output | 32 | Stored program counter |

## Verification
The hardest state to reach is a banked register being overwritten through the wrong bank. Reaching it takes a mode change, a write, a second mode change and a read, and the final read must come back unchanged. The stimulus therefore enters exception modes by strobe, changes them by direct status loads that include unlisted mode codes, and returns by strobe. It mixes register writes and same-cycle reads of the written index throughout. A behavioural model with separate per-mode arrays predicts every read, so aliasing between banks appears as a mismatch many cycles after the write that caused it.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
    localparam int XLEN          = 32;
    localparam int IDXW          = 4;
    localparam int MODEW         = 5;
    localparam int ST_NARROW     = 5;
    localparam int N_BASE        = 15;
    localparam int FIQ_FIRST     = 8;
    localparam int N_FIQ         = 7;
    localparam int SMALL_FIRST   = 13;
    localparam int N_SMALL       = 2;
    localparam int N_SMALL_BANKS = 4;
    localparam int N_SAVED       = 5;
    localparam int NPHYS         = N_BASE + N_FIQ + N_SMALL * N_SMALL_BANKS;
    localparam int SLOTW         = $clog2(NPHYS);
    localparam int PC_IDX        = 15;
    localparam int LR_IDX        = 14;
    localparam int PC_AHEAD_WIDE   = 8;
    localparam int PC_AHEAD_NARROW = 4;

    localparam logic [MODEW-1:0] MODE_USR = 5'b10000;
    localparam logic [MODEW-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODEW-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODEW-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODEW-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODEW-1:0] MODE_UND = 5'b11011;
    localparam logic [MODEW-1:0] MODE_SYS = 5'b11111;

    localparam logic [XLEN-1:0] STATUS_RESET = 32'h0000_00D3;

    typedef enum logic [2:0] {
        BK_BASE = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

    typedef logic [SLOTW-1:0] slot_t;

    function automatic bank_e bank_of(input logic [MODEW-1:0] m);
        case (m)
            MODE_FIQ: return BK_FIQ;
            MODE_IRQ: return BK_IRQ;
            MODE_SVC: return BK_SVC;
            MODE_ABT: return BK_ABT;
            MODE_UND: return BK_UND;
            default:  return BK_BASE;
        endcase
    endfunction

    // Physical slot layout: 0..14 base, then fast-interrupt 8..14,
    // then pairs (13,14) for irq, svc, abt, und in bank order.
    function automatic slot_t slot_of(input bank_e b, input logic [IDXW-1:0] idx);
        int s;
        s = int'(idx);
        if (b == BK_FIQ && int'(idx) >= FIQ_FIRST && int'(idx) < PC_IDX)
            s = N_BASE + int'(idx) - FIQ_FIRST;
        else if (b != BK_BASE && b != BK_FIQ && int'(idx) >= SMALL_FIRST && int'(idx) < PC_IDX)
            s = N_BASE + N_FIQ + (int'(b) - int'(BK_IRQ)) * N_SMALL + int'(idx) - SMALL_FIRST;
        return slot_t'(s);
    endfunction
endpackage

// File: rtl/bankrf_decode.sv
module bankrf_decode
    import bankrf_pkg::*;
#(
    parameter int P_IDXW  = IDXW,
    parameter int P_MODEW = MODEW,
    parameter int P_SLOTW = SLOTW
) (
    input  logic [P_MODEW-1:0] cur_mode,
    input  logic [P_MODEW-1:0] exc_mode,
    input  logic [P_IDXW-1:0]  idx_a,
    input  logic [P_IDXW-1:0]  idx_b,
    input  logic [P_IDXW-1:0]  idx_w,
    output bank_e              cur_bank,
    output bank_e              exc_bank,
    output logic               cur_has_saved,
    output logic               exc_valid,
    output logic [P_SLOTW-1:0] slot_a,
    output logic [P_SLOTW-1:0] slot_b,
    output logic [P_SLOTW-1:0] slot_w,
    output logic [P_SLOTW-1:0] slot_lr
);
    localparam logic [P_IDXW-1:0] LR_CODE = P_IDXW'(LR_IDX);

    always_comb begin
        cur_bank      = bank_of(cur_mode);
        exc_bank      = bank_of(exc_mode);
        cur_has_saved = (cur_bank != BK_BASE);
        exc_valid     = (exc_bank != BK_BASE);
        slot_a        = slot_of(cur_bank, idx_a);
        slot_b        = slot_of(cur_bank, idx_b);
        slot_w        = slot_of(cur_bank, idx_w);
        slot_lr       = slot_of(exc_bank, LR_CODE);
    end
endmodule

// File: rtl/bankrf_gpr.sv
module bankrf_gpr #(
    parameter int P_XLEN  = 32,
    parameter int P_NPHYS = 30,
    parameter int P_SLOTW = 5,
    parameter int P_NRD   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_main,
    input  logic [P_SLOTW-1:0]              slot_main,
    input  logic [P_XLEN-1:0]               data_main,
    input  logic                            we_link,
    input  logic [P_SLOTW-1:0]              slot_link,
    input  logic [P_XLEN-1:0]               data_link,
    input  logic [P_NRD-1:0][P_SLOTW-1:0]   rd_slot,
    output logic [P_NRD-1:0][P_XLEN-1:0]    rd_val
);
    logic [P_XLEN-1:0] gpr_q [P_NPHYS];
    logic [P_XLEN-1:0] gpr_d [P_NPHYS];

    always_comb begin
        for (int i = 0; i < P_NPHYS; i++) gpr_d[i] = gpr_q[i];
        if (we_main && int'(slot_main) < P_NPHYS) gpr_d[slot_main] = data_main;
        if (we_link && int'(slot_link) < P_NPHYS) gpr_d[slot_link] = data_link;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < P_NPHYS; i++) gpr_q[i] <= '0;
        end else begin
            for (int i = 0; i < P_NPHYS; i++) gpr_q[i] <= gpr_d[i];
        end
    end

    for (genvar p = 0; p < P_NRD; p++) begin : g_rd
        assign rd_val[p] = (int'(rd_slot[p]) < P_NPHYS) ? gpr_q[rd_slot[p]] : '0;
    end
endmodule

// File: rtl/bankrf_ctrl.sv
module bankrf_ctrl
    import bankrf_pkg::*;
#(
    parameter int P_XLEN   = XLEN,
    parameter int P_MODEW  = MODEW,
    parameter int P_NSAVED = N_SAVED
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exc_take,
    input  logic [P_MODEW-1:0]  exc_mode,
    input  bank_e               exc_bank,
    input  logic                ret_take,
    input  bank_e               cur_bank,
    input  logic                st_we,
    input  logic [P_XLEN-1:0]   st_wd,
    input  logic                sv_we,
    input  logic [P_XLEN-1:0]   sv_wd,
    input  logic                br_we,
    input  logic [P_XLEN-1:0]   br_wd,
    input  logic                pc_we,
    input  logic [P_XLEN-1:0]   pc_wd,
    output logic [P_XLEN-1:0]   status_o,
    output logic [P_XLEN-1:0]   saved_o,
    output logic [P_XLEN-1:0]   pc_o
);
    typedef struct packed {
        logic [P_NSAVED-1:0][P_XLEN-1:0] saved;
        logic [P_XLEN-1:0]               status;
        logic [P_XLEN-1:0]               pc;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic [2:0] exc_slot, cur_slot;

    assign exc_slot = 3'(exc_bank) - 3'd1;
    assign cur_slot = 3'(cur_bank) - 3'd1;

    always_comb begin
        ctl_d = ctl_q;
        if (exc_take) begin
            ctl_d.saved[exc_slot] = ctl_q.status;
            ctl_d.status = {ctl_q.status[P_XLEN-1:ST_NARROW+1], 1'b0, exc_mode};
        end else if (ret_take) begin
            ctl_d.status = ctl_q.saved[cur_slot];
        end else begin
            if (st_we) ctl_d.status = st_wd;
            if (sv_we && cur_bank != BK_BASE) ctl_d.saved[cur_slot] = sv_wd;
        end
        if (br_we)      ctl_d.pc = br_wd;
        else if (pc_we) ctl_d.pc = pc_wd;
        if (ctl_d.status[ST_NARROW]) ctl_d.pc[0]   = 1'b0;
        else                         ctl_d.pc[1:0] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.saved  <= '0;
            ctl_q.status <= P_XLEN'(STATUS_RESET);
            ctl_q.pc     <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign status_o = ctl_q.status;
    assign pc_o     = ctl_q.pc;
    assign saved_o  = (cur_bank == BK_BASE) ? '0 : ctl_q.saved[cur_slot];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int P_XLEN  = XLEN,
    parameter int P_IDXW  = IDXW,
    parameter int P_MODEW = MODEW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_IDXW-1:0]  rd_a_idx,
    output logic [P_XLEN-1:0]  rd_a_data,
    input  logic [P_IDXW-1:0]  rd_b_idx,
    output logic [P_XLEN-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic [P_IDXW-1:0]  wr_idx,
    input  logic [P_XLEN-1:0]  wr_data,
    input  logic               pc_wr_en,
    input  logic [P_XLEN-1:0]  pc_wr_data,
    input  logic               st_wr_en,
    input  logic [P_XLEN-1:0]  st_wr_data,
    input  logic               sv_wr_en,
    input  logic [P_XLEN-1:0]  sv_wr_data,
    input  logic               exc_en,
    input  logic [P_MODEW-1:0] exc_mode,
    input  logic [P_XLEN-1:0]  exc_ret_addr,
    input  logic               exc_ret,
    output logic [P_XLEN-1:0]  status_o,
    output logic [P_XLEN-1:0]  saved_o,
    output logic [P_XLEN-1:0]  pc_o
);
    localparam int NRD = 2;
    localparam logic [P_IDXW-1:0] PC_CODE = P_IDXW'(PC_IDX);

    bank_e       cur_bank, exc_bank;
    logic        cur_has_saved, exc_valid;
    slot_t       slot_a, slot_b, slot_w, slot_lr;
    logic        quiet, exc_take, ret_take, gpr_we, br_we;
    logic [NRD-1:0][SLOTW-1:0]  rd_slot;
    logic [NRD-1:0][P_XLEN-1:0] rd_raw;
    logic [NRD-1:0][P_IDXW-1:0] rd_idx;
    logic [NRD-1:0][P_XLEN-1:0] rd_out;
    logic [P_XLEN-1:0] pc_ahead;

    bankrf_decode #(.P_IDXW(P_IDXW), .P_MODEW(P_MODEW), .P_SLOTW(SLOTW)) u_decode (
        .cur_mode      (status_o[P_MODEW-1:0]),
        .exc_mode      (exc_mode),
        .idx_a         (rd_a_idx),
        .idx_b         (rd_b_idx),
        .idx_w         (wr_idx),
        .cur_bank      (cur_bank),
        .exc_bank      (exc_bank),
        .cur_has_saved (cur_has_saved),
        .exc_valid     (exc_valid),
        .slot_a        (slot_a),
        .slot_b        (slot_b),
        .slot_w        (slot_w),
        .slot_lr       (slot_lr)
    );

    assign quiet    = exc_en | exc_ret;
    assign exc_take = exc_en & exc_valid;
    assign ret_take = exc_ret & ~exc_en & cur_has_saved;
    assign gpr_we   = wr_en & ~quiet & (wr_idx != PC_CODE);
    assign br_we    = wr_en & ~quiet & (wr_idx == PC_CODE);

    assign rd_slot[0] = slot_a;
    assign rd_slot[1] = slot_b;
    assign rd_idx[0]  = rd_a_idx;
    assign rd_idx[1]  = rd_b_idx;

    bankrf_gpr #(.P_XLEN(P_XLEN), .P_NPHYS(NPHYS), .P_SLOTW(SLOTW), .P_NRD(NRD)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_main   (gpr_we),
        .slot_main (slot_w),
        .data_main (wr_data),
        .we_link   (exc_take),
        .slot_link (slot_lr),
        .data_link (exc_ret_addr),
        .rd_slot   (rd_slot),
        .rd_val    (rd_raw)
    );

    bankrf_ctrl #(.P_XLEN(P_XLEN), .P_MODEW(P_MODEW), .P_NSAVED(N_SAVED)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_take (exc_take),
        .exc_mode (exc_mode),
        .exc_bank (exc_bank),
        .ret_take (ret_take),
        .cur_bank (cur_bank),
        .st_we    (st_wr_en & ~quiet),
        .st_wd    (st_wr_data),
        .sv_we    (sv_wr_en & ~quiet),
        .sv_wd    (sv_wr_data),
        .br_we    (br_we),
        .br_wd    (wr_data),
        .pc_we    (pc_wr_en),
        .pc_wd    (pc_wr_data),
        .status_o (status_o),
        .saved_o  (saved_o),
        .pc_o     (pc_o)
    );

    assign pc_ahead = pc_o + (status_o[ST_NARROW] ? P_XLEN'(PC_AHEAD_NARROW)
                                                   : P_XLEN'(PC_AHEAD_WIDE));

    for (genvar p = 0; p < NRD; p++) begin : g_port
        assign rd_out[p] = (rd_idx[p] == PC_CODE) ? pc_ahead : rd_raw[p];
    end

    assign rd_a_data = rd_out[0];
    assign rd_b_data = rd_out[1];
endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk
    import bankrf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IDXW-1:0]   rd_a_idx,
    input logic [XLEN-1:0]   rd_a_data,
    input logic              exc_en,
    input logic [MODEW-1:0]  exc_mode,
    input logic              exc_ret,
    input logic [XLEN-1:0]   status_o,
    input logic [XLEN-1:0]   saved_o,
    input logic [XLEN-1:0]   pc_o
);
    logic in_base;
    logic exc_ok;
    assign in_base = (bank_of(status_o[MODEW-1:0]) == BK_BASE);
    assign exc_ok  = (bank_of(exc_mode) != BK_BASE);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (status_o == STATUS_RESET && pc_o == '0));

    p_entry_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && exc_ok) |=> (status_o[MODEW-1:0] == $past(exc_mode) && !status_o[ST_NARROW]));

    p_entry_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && exc_ok) |=> (saved_o == $past(status_o)));

    p_return_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ret && !exc_en && !in_base) |=> (status_o == $past(saved_o)));

    p_return_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ret && !exc_en && in_base) |=> $stable(status_o));

    p_saved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_base |-> (saved_o == '0));

    p_pc_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 4'hF) |-> (rd_a_data == pc_o + (status_o[ST_NARROW] ? 32'd4 : 32'd8)));

    p_pc_align_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[ST_NARROW] |-> (pc_o[1:0] == 2'b00));

    p_pc_align_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[ST_NARROW] |-> (pc_o[0] == 1'b0));
endmodule

bind banked_regfile bankrf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .exc_en    (exc_en),
    .exc_mode  (exc_mode),
    .exc_ret   (exc_ret),
    .status_o  (status_o),
    .saved_o   (saved_o),
    .pc_o      (pc_o)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0, pc_wr_en = 1'b0, st_wr_en = 1'b0, sv_wr_en = 1'b0;
    logic [31:0] wr_data = '0, pc_wr_data = '0, st_wr_data = '0, sv_wr_data = '0;
    logic        exc_en = 1'b0, exc_ret = 1'b0;
    logic [4:0]  exc_mode = '0;
    logic [31:0] exc_ret_addr = '0;
    logic [31:0] status_o, saved_o, pc_o;

    int total = 0;
    int fails = 0;
    string force_tag = "";
    bit last_ret = 1'b0;

    always #4 clk = ~clk;

    banked_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
        .sv_wr_en(sv_wr_en), .sv_wr_data(sv_wr_data),
        .exc_en(exc_en), .exc_mode(exc_mode), .exc_ret_addr(exc_ret_addr),
        .exc_ret(exc_ret),
        .status_o(status_o), .saved_o(saved_o), .pc_o(pc_o)
    );

    // Reference model: separate arrays per kind of storage
    logic [31:0] m_base [15];
    logic [31:0] m_fiq  [7];
    logic [31:0] m_pair [4][2];
    logic [31:0] m_saved[5];
    logic [31:0] m_status, m_pc;

    logic [4:0] mode_pool [9] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                  5'b10111, 5'b11011, 5'b11111, 5'b00000, 5'b10101};

    function automatic int bk(input logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [31:0] mread(input int idx);
        int b = bk(m_status[4:0]);
        if (idx == 15) return m_pc + (m_status[5] ? 32'd4 : 32'd8);
        if (idx < 8) return m_base[idx];
        if (b == 1) return m_fiq[idx-8];
        if (b >= 2 && idx >= 13) return m_pair[b-2][idx-13];
        return m_base[idx];
    endfunction

    task automatic mwrite(input int b, input int idx, input logic [31:0] v);
        if (idx < 8) m_base[idx] = v;
        else if (b == 1) m_fiq[idx-8] = v;
        else if (b >= 2 && idx >= 13) m_pair[b-2][idx-13] = v;
        else m_base[idx] = v;
    endtask

    task automatic mreset();
        for (int i = 0; i < 15; i++) m_base[i] = '0;
        for (int i = 0; i < 7; i++) m_fiq[i] = '0;
        for (int i = 0; i < 4; i++) begin m_pair[i][0] = '0; m_pair[i][1] = '0; end
        for (int i = 0; i < 5; i++) m_saved[i] = '0;
        m_status = 32'h0000_00D3;
        m_pc = '0;
    endtask

    task automatic mstep();
        logic [31:0] old_st = m_status;
        int b = bk(old_st[4:0]);
        int eb = bk(exc_mode);
        bit hold = exc_en || exc_ret;
        logic [31:0] npc = m_pc;
        last_ret = 1'b0;
        if (exc_en) begin
            if (eb != 0) begin
                m_saved[eb-1] = old_st;
                mwrite(eb, 14, exc_ret_addr);
                m_status = {old_st[31:6], 1'b0, exc_mode};
            end
        end else if (exc_ret) begin
            last_ret = 1'b1;
            if (b != 0) m_status = m_saved[b-1];
        end else begin
            if (wr_en && wr_idx != 4'd15) mwrite(b, int'(wr_idx), wr_data);
            if (st_wr_en) m_status = st_wr_data;
            if (sv_wr_en && b != 0) m_saved[b-1] = sv_wr_data;
        end
        if (wr_en && wr_idx == 4'd15 && !hold) npc = wr_data;
        else if (pc_wr_en) npc = pc_wr_data;
        if (m_status[5]) npc[0] = 1'b0; else npc[1:0] = 2'b00;
        m_pc = npc;
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string rtag(input logic [3:0] idx);
        int b = bk(m_status[4:0]);
        if (force_tag != "") return force_tag;
        if (idx == 4'd15) return "R9";
        if (wr_en && wr_idx == idx) return "R11";
        if (idx < 8) return "R2";
        if (b == 1) return "R3";
        if (b >= 2) return "R4";
        return "R5";
    endfunction

    task automatic compare();
        int b = bk(m_status[4:0]);
        check(rtag(rd_a_idx), "rd_a", rd_a_data, mread(int'(rd_a_idx)));
        check(rtag(rd_b_idx), "rd_b", rd_b_data, mread(int'(rd_b_idx)));
        check(force_tag != "" ? force_tag : (last_ret ? "R7" : "R6"), "status", status_o, m_status);
        check(force_tag != "" ? force_tag : "R10", "pc", pc_o, m_pc);
        check(force_tag != "" ? force_tag : (b == 0 ? "R8" : "R7"), "saved",
              saved_o, (b == 0) ? 32'h0 : m_saved[b-1]);
    endtask

    task automatic idle();
        wr_en = 0; pc_wr_en = 0; st_wr_en = 0; sv_wr_en = 0; exc_en = 0; exc_ret = 0;
    endtask

    task automatic cycle();
        #1 compare();
        @(posedge clk);
        mstep();
        @(negedge clk);
    endtask

    task automatic rand_inputs();
        wr_en      = ($urandom_range(0, 9) < 6);
        wr_idx     = 4'($urandom_range(0, 15));
        wr_data    = $urandom;
        pc_wr_en   = ($urandom_range(0, 9) < 7);
        pc_wr_data = ($urandom_range(0, 3) == 0) ? $urandom : m_pc + 32'd4;
        st_wr_en   = ($urandom_range(0, 99) < 8);
        st_wr_data = {$urandom, 1'b0, 5'b0};
        st_wr_data[5]   = 1'($urandom_range(0, 1));
        st_wr_data[4:0] = mode_pool[$urandom_range(0, 8)];
        sv_wr_en   = ($urandom_range(0, 99) < 8);
        sv_wr_data = $urandom;
        exc_en     = ($urandom_range(0, 99) < 5);
        exc_mode   = mode_pool[$urandom_range(0, 8)];
        exc_ret_addr = $urandom;
        exc_ret    = ($urandom_range(0, 99) < 5);
        rd_a_idx   = 4'($urandom_range(0, 15));
        rd_b_idx   = 4'($urandom_range(0, 15));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        mreset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, checked while reset is still asserted
        force_tag = "R1";
        #1 compare();
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
            cycle();
        end
        force_tag = "";

        // R11: write and read the same index in one cycle
        wr_en = 1; wr_idx = 4'd3; wr_data = 32'hCAFE_0003; rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        cycle();
        idle(); cycle();

        // R6: enter fast-interrupt mode, fill its bank
        exc_en = 1; exc_mode = 5'b10001; exc_ret_addr = 32'h0000_1234; rd_a_idx = 4'd14;
        cycle(); idle();
        for (int i = 8; i < 15; i++) begin
            wr_en = 1; wr_idx = 4'(i); wr_data = 32'hF100_0000 + 32'(i); rd_a_idx = 4'(i);
            cycle();
        end
        idle();
        // R7: return to supervisor, banked values must not show
        exc_ret = 1; cycle(); idle();
        for (int i = 8; i < 15; i++) begin rd_a_idx = 4'(i); rd_b_idx = 4'(i - 8); cycle(); end

        // R5/R8: user mode, unlisted mode code, saved write ignored
        st_wr_en = 1; st_wr_data = 32'h0000_0010; cycle(); idle();
        sv_wr_en = 1; sv_wr_data = 32'hDEAD_BEEF; cycle(); idle();
        st_wr_en = 1; st_wr_data = 32'h0000_0005; cycle(); idle();
        wr_en = 1; wr_idx = 4'd13; wr_data = 32'h5555_AAAA; rd_a_idx = 4'd13; cycle(); idle();
        exc_ret = 1; cycle(); idle();
        // R9/R10: narrow state, odd branch target
        st_wr_en = 1; st_wr_data = 32'h0000_0030; cycle(); idle();
        wr_en = 1; wr_idx = 4'd15; wr_data = 32'h0000_0103; rd_a_idx = 4'd15; cycle(); idle();
        rd_a_idx = 4'd15; cycle();

        for (int n = 0; n < 6000; n++) begin
            rand_inputs();
            cycle();
        end
        idle(); cycle();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule